// File: doc/BRIEF.md
# Cascadable Bidirectional Column Data Capture

This block gathers one display line of 6-bit gray-scale codes for a column driver that sits in a chain of identical drivers. On every clock a 36-bit word of six dot codes arrives. A one-hot slot pointer steers each word into its group of six columns in a line-wide register. Capture starts when the start input on the active side is sampled high. The block hands a one-clock start pulse on to the next driver in the chain, and it stops accepting data by itself a fixed number of clocks after the start. A rising edge of the line strobe clears the slot pointer.

A direction input picks which start input is active, which start output carries the forwarded pulse, and whether columns fill upward from column 0 or downward from the last column. Two inversion controls can complement the lower half and the upper half of each input word as it is stored. The number of columns is a parameter. With WORDS = NUM_COLS/6, the forwarded pulse appears on clock WORDS and capture halts after clock WORDS+2.

A sequencer holds three named states. IDLE means no capture is running. FILL means words are being written. TAIL covers the two trailing clocks. The transitions are: IDLE→FILL when a start is sampled; FILL→TAIL on the clock that writes the last slot, which also raises the forwarded pulse; TAIL→IDLE two clocks later. Any state goes to IDLE on a strobe rising edge. Any state goes to FILL on a start, and a start wins over a strobe edge in the same clock.

Top module: `column_capture`

## Requirements
- R1: After reset every column of `line_data` is 0 and both start outputs are low.
- R2: With `dir_right`=1, `start_r_in` is the active start input. The word taken on clock k after the start (k = 1..WORDS) puts its dot d (bits [6d+5:6d]) into column 6(k-1)+d. Column c occupies `line_data` bits [6c+5:6c].
- R3: With `dir_right`=0, `start_l_in` is the active start input, and dot d of word k goes to column NUM_COLS-1-(6(k-1)+d).
- R4: A start pulse on the inactive side's input starts no capture and no forwarded pulse, so the stored line stays unchanged.
- R5: After the rising edge on clock WORDS following the start, the forwarded start output is high for exactly one clock. It appears on `start_l_out` when `dir_right`=1 and on `start_r_out` when `dir_right`=0. The other start output stays low.
- R6: From clock WORDS+2 after the start until the next start, input words are ignored and `line_data` does not change.
- R7: `inv_lo`=1 stores dots 0..2 (bits 17:0) complemented. `inv_hi`=1 stores dots 3..5 (bits 35:18) complemented. Each control acts independently, and a low level stores the data unchanged.
- R8: A rising edge of `strobe` (sampled low, then high) clears the pointer. The word on that clock and all later words are not stored, no forwarded pulse follows, and the columns already written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | 1: fill from column 0 upward; 0: fill from the last column downward |
| start_r_in | input | 1 | Start input, active when dir_right=1 |
| start_l_in | input | 1 | Start input, active when dir_right=0 |
| start_r_out | output | 1 | Forwarded start pulse when dir_right=0 |
| start_l_out | output | 1 | Forwarded start pulse when dir_right=1 |
| dot_word | input | 36 | Six 6-bit dot codes, dot d at bits [6d+5:6d] |
| inv_lo | input | 1 | Complement dots 0..2 on load |
| inv_hi | input | 1 | Complement dots 3..5 on load |
| strobe | input | 1 | Line strobe; a rising edge clears the pointer |
| line_data | output | NUM_COLS*6 | Stored line, column c at bits [6c+5:6c] |

## Verification
A table of lines is run in both fill directions with all four settings of the inversion controls. Each dot value is derived from a seed, its word index and its dot index, so a dot written to the wrong column, a mirrored order that is off, or a half inverted by the wrong control all show up as a mismatched column. On every line the forwarded pulse is sampled on the expected clock and the clock after, and on both output ports, which separates an early, late, long or misrouted pulse. Directed runs then drive a start on the wrong side, a strobe edge in the middle of a line, and words with no start after a halt. For each of these the stored line is compared with the preserved expectation.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int DOT_W         = 6;
    localparam int DOTS_PER_WORD = 6;
    localparam int WORD_W        = DOT_W * DOTS_PER_WORD;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_TAIL = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cap_sequencer.sv
module cap_sequencer
    import cap_pkg::*;
#(
    parameter int WORDS = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_seen,
    input  logic strobe,
    output logic load_ptr,
    output logic clear_ptr,
    output logic advance,
    output logic cascade
);
    localparam int CW = $clog2(WORDS + 3) + 1;
    localparam logic [CW-1:0] LAST_FILL = CW'(WORDS - 1);
    localparam logic [CW-1:0] LAST_TAIL = CW'(WORDS + 1);

    cap_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic strobe_q;
    logic strobe_rise;
    logic cascade_q;

    assign strobe_rise = strobe & ~strobe_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_FILL: if (cnt_q == LAST_FILL) state_d = ST_TAIL;
            ST_TAIL: if (cnt_q == LAST_TAIL) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (strobe_rise) state_d = ST_IDLE;
        if (start_seen)  state_d = ST_FILL;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            strobe_q  <= 1'b0;
            cascade_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            strobe_q  <= strobe;
            cascade_q <= (state_q == ST_FILL) && (state_d == ST_TAIL);
            if (start_seen)
                cnt_q <= '0;
            else if (state_q != ST_IDLE)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        load_ptr  = start_seen;
        clear_ptr = strobe_rise & ~start_seen;
        advance   = (state_q == ST_FILL) && !strobe_rise;
        cascade   = cascade_q;
    end

    assert_cascade_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_q |=> !cascade_q);
    assert_cascade_in_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_q |-> (state_q == ST_TAIL));
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_seen) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cap_pointer.sv
module cap_pointer #(
    parameter int WORDS = 70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic             advance,
    output logic [WORDS-1:0] wr_slot
);
    logic [WORDS-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= WORDS'(1);
        else if (clear)
            ptr_q <= '0;
        else if (advance)
            ptr_q <= ptr_q << 1;
    end

    assign wr_slot = advance ? ptr_q : '0;

    assert_ptr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q));
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (ptr_q == '0));
endmodule

// File: rtl/cap_datareg.sv
module cap_datareg
    import cap_pkg::*;
#(
    parameter int WORDS    = 70,
    parameter int NUM_COLS = 420
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         word,
    input  logic                      inv_lo,
    input  logic                      inv_hi,
    input  logic                      dir_fwd,
    input  logic [WORDS-1:0]          wr_slot,
    output logic [NUM_COLS*DOT_W-1:0] line
);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] word_fix;
    assign word_fix = word ^ {{(WORD_W - HALF_W){inv_hi}}, {HALF_W{inv_lo}}};

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam int FW = c / DOTS_PER_WORD;
        localparam int FD = c % DOTS_PER_WORD;
        localparam int MC = NUM_COLS - 1 - c;
        localparam int RW = MC / DOTS_PER_WORD;
        localparam int RD = MC % DOTS_PER_WORD;
        logic [DOT_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (dir_fwd && wr_slot[FW])
                q <= word_fix[FD*DOT_W +: DOT_W];
            else if (!dir_fwd && wr_slot[RW])
                q <= word_fix[RD*DOT_W +: DOT_W];
        end
        assign line[c*DOT_W +: DOT_W] = q;
    end
endmodule

// File: rtl/column_capture.sv
module column_capture
    import cap_pkg::*;
#(
    parameter int NUM_COLS = 420
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dir_right,
    input  logic                      start_r_in,
    input  logic                      start_l_in,
    output logic                      start_r_out,
    output logic                      start_l_out,
    input  logic [WORD_W-1:0]         dot_word,
    input  logic                      inv_lo,
    input  logic                      inv_hi,
    input  logic                      strobe,
    output logic [NUM_COLS*DOT_W-1:0] line_data
);
    localparam int WORDS = NUM_COLS / DOTS_PER_WORD;

    logic start_seen;
    logic load_ptr, clear_ptr, advance, cascade;
    logic [WORDS-1:0] wr_slot;

    assign start_seen = dir_right ? start_r_in : start_l_in;

    cap_sequencer #(.WORDS(WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_seen (start_seen),
        .strobe     (strobe),
        .load_ptr   (load_ptr),
        .clear_ptr  (clear_ptr),
        .advance    (advance),
        .cascade    (cascade)
    );

    cap_pointer #(.WORDS(WORDS)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_ptr),
        .clear   (clear_ptr),
        .advance (advance),
        .wr_slot (wr_slot)
    );

    cap_datareg #(.WORDS(WORDS), .NUM_COLS(NUM_COLS)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .word    (dot_word),
        .inv_lo  (inv_lo),
        .inv_hi  (inv_hi),
        .dir_fwd (dir_right),
        .wr_slot (wr_slot),
        .line    (line_data)
    );

    assign start_l_out = dir_right & cascade;
    assign start_r_out = ~dir_right & cascade;

    assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(line_data));
endmodule

// File: tb/column_capture_bench.sv
module column_capture_bench;
    localparam int NCOLS = 24;
    localparam int WORDS = NCOLS / 6;
    localparam int LW    = NCOLS * 6;

    // {dir, inv_lo, inv_hi, seed[6:0]}
    localparam logic [9:0] VEC [0:5] = '{
        {1'b1, 1'b0, 1'b0, 7'd3},
        {1'b0, 1'b0, 1'b0, 7'd17},
        {1'b1, 1'b1, 1'b0, 7'd29},
        {1'b0, 1'b0, 1'b1, 7'd41},
        {1'b1, 1'b1, 1'b1, 7'd55},
        {1'b0, 1'b1, 1'b1, 7'd66}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic dir_right = 1, start_r_in = 0, start_l_in = 0;
    logic start_r_out, start_l_out;
    logic [35:0] dot_word = '0;
    logic inv_lo = 0, inv_hi = 0, strobe = 0;
    logic [LW-1:0] line_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [5:0] exp_col [NCOLS];

    always #4 clk = ~clk;

    column_capture #(.NUM_COLS(NCOLS)) u_column_capture (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right),
        .start_r_in(start_r_in), .start_l_in(start_l_in),
        .start_r_out(start_r_out), .start_l_out(start_l_out),
        .dot_word(dot_word), .inv_lo(inv_lo), .inv_hi(inv_hi),
        .strobe(strobe), .line_data(line_data)
    );

    function automatic logic [5:0] dotval(int seed, int w, int d);
        return 6'(seed * 11 + w * 7 + d * 3 + 5);
    endfunction

    function automatic logic [LW-1:0] exp_line();
        logic [LW-1:0] v;
        for (int c = 0; c < NCOLS; c++) v[c*6 +: 6] = exp_col[c];
        return v;
    endfunction

    task automatic check(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one line: strobe_at < 0 means no strobe; wrong_side drives the inactive start input
    task automatic run_line(bit d, bit il, bit ih, int seed, int strobe_at, bit wrong_side);
        bit cas_exp;
        @(negedge clk);
        dir_right = d; inv_lo = il; inv_hi = ih;
        if (d ^ wrong_side) start_r_in = 1; else start_l_in = 1;
        cas_exp = !wrong_side && (strobe_at < 0);
        for (int w = 0; w < WORDS + 4; w++) begin
            @(negedge clk);
            start_r_in = 0; start_l_in = 0;
            strobe = (w == strobe_at);
            for (int k = 0; k < 6; k++) dot_word[k*6 +: 6] = dotval(seed, w, k);
            if (!wrong_side && w < WORDS && (strobe_at < 0 || w < strobe_at)) begin
                for (int k = 0; k < 6; k++) begin
                    int col;
                    logic [5:0] v;
                    col = d ? 6*w + k : NCOLS - 1 - (6*w + k);
                    v = dotval(seed, w, k) ^ {6{(k < 3) ? il : ih}};
                    exp_col[col] = v;
                end
            end
            if (w == WORDS) begin
                // rising edge WORDS has passed
                check("R5 pulse on active output", LW'(d ? start_l_out : start_r_out), LW'(cas_exp));
                check("R5 other output low", LW'(d ? start_r_out : start_l_out), LW'(0));
            end
            if (w == WORDS + 1)
                check("R5 pulse lasts one clock", LW'({start_l_out, start_r_out}), LW'(0));
        end
        @(negedge clk);
        strobe = 0;
    endtask

    initial begin
        for (int c = 0; c < NCOLS; c++) exp_col[c] = '0;
        repeat (3) @(negedge clk);
        check("R1 line after reset", line_data, exp_line());
        check("R1 start outputs after reset", LW'({start_l_out, start_r_out}), LW'(0));
        rst_n = 1;
        repeat (2) @(negedge clk);

        // table of lines: R2/R3 placement, R7 inversion
        for (int i = 0; i < 6; i++) begin
            run_line(VEC[i][9], VEC[i][8], VEC[i][7], int'(VEC[i][6:0]), -1, 0);
            check(VEC[i][9] ? "R2 R7 forward line" : "R3 R7 mirrored line", line_data, exp_line());
        end

        // R4: start on the inactive side, both directions
        run_line(1, 0, 0, 90, -1, 1);
        check("R4 inactive start ignored (dir=1)", line_data, exp_line());
        run_line(0, 0, 0, 91, -1, 1);
        check("R4 inactive start ignored (dir=0)", line_data, exp_line());

        // R8: strobe edge part-way through a line
        run_line(1, 0, 0, 100, 2, 0);
        check("R8 strobe stops capture (dir=1)", line_data, exp_line());
        run_line(0, 1, 0, 110, 1, 0);
        check("R8 strobe stops capture (dir=0)", line_data, exp_line());

        // R6: words with no start after the halt
        run_line(1, 0, 1, 120, -1, 0);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            dot_word = {6{6'(w * 9 + 1)}};
        end
        @(negedge clk);
        check("R6 words ignored after halt", line_data, exp_line());

        // R1: reset again
        rst_n = 0;
        for (int c = 0; c < NCOLS; c++) exp_col[c] = '0;
        @(negedge clk);
        check("R1 line cleared by reset", line_data, exp_line());

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule